// File: doc/BRIEF.md
# Framebuffer Control and Vertical-Sync Interrupt Register Bank

This block is the byte-wide register file that sits beside a simple framebuffer controller. It decodes the upper half of a 32-byte register window. It holds a control byte whose top bit arms the vertical-sync interrupt, and a status byte with a sticky pending flag. It also provides a run of general-purpose read/write bytes. The display timing logic sends a one-cycle pulse at each frame end. When the interrupt is armed, that pulse latches the pending flag, and the block raises a level interrupt toward the processor.

Software acknowledges the interrupt by writing any value to the status byte. A status read always merges constant identification bits into the stored flag: a monitor-sense code and a colour-board marker. The lower half of the window belongs to other logic. Here it reads as zero and ignores writes.

Writes are single-cycle strobes. Read data is combinational from the address.

Top module: `fbc_irq_regs`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0, the control byte (offset 0x10) reads 0x00, the status byte (offset 0x11) reads 0x61, and every general-purpose byte reads 0x00.
- R2: A write to offset 0x10 stores the full byte, and the stored byte reads back from 0x10 in the following cycle.
- R3: A `frame_end` pulse sampled while control bit 7 is 1 sets the pending flag, and `irq` is 1 from the next cycle.
- R4: A `frame_end` pulse sampled while control bit 7 is 0 leaves the pending flag clear and `irq` at 0.
- R5: A write of any data value to offset 0x11 clears the pending flag and drops `irq` in the next cycle. A write while the flag is already clear changes nothing.
- R6: A read of offset 0x11 returns the pending flag in bit 7, with bits 6, 5 and 0 forced to 1 and all other bits 0. The result is 0xE1 when pending and 0x61 when clear.
- R7: When a `frame_end` pulse with control bit 7 set and a status write fall in the same cycle, the pending flag is set afterwards.
- R8: Offsets 0x12 to 0x1F are fourteen independent bytes. Each reads back the last value written to it.
- R9: Offsets 0x00 to 0x0F read as 0x00. Writes to them change no register.
- R10: `irq` equals the pending flag ANDed with control bit 7. Clearing bit 7 drops `irq` but keeps the flag, and setting bit 7 again raises `irq`.
- R11: Once set, the pending flag stays set until a status write clears it, whatever cycles pass without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| frame_end | input | 1 | One-cycle pulse from display timing at each frame end |
| irq | output | 1 | Level interrupt request |

## Verification
Assertions watch the pending flag on every cycle. They check that an armed frame end sets it, that a status write without a frame end clears it, and that the set wins a collision. They also check that the flag cannot appear without an armed frame end and that it holds while nothing touches it. Assertions further check that each general-purpose byte captures its write. The bench covers the rest by scenario: the exact bytes seen on reads with the ID bits merged in, the lower-half addresses reading zero and leaving other registers alone, and `irq` following the enable bit while a flag is pending. A behavioural reference model is compared with both outputs on every clock. That model is driven by both directed sequences and a pseudo-random stream of writes and frame pulses.

// File: rtl/fbc_regs_pkg.sv
// Package: shared constants for the framebuffer control register bank.
// Assumes byte-wide registers; bit positions are fixed by software use.
package fbc_regs_pkg;
    localparam int DATA_W      = 8;
    localparam int ARM_BIT     = 7;     // control bit that arms the interrupt
    localparam int PEND_BIT    = 7;     // status bit holding the pending flag
    localparam int CTRL_OFS    = 16;    // control byte offset
    localparam int STAT_OFS    = 17;    // status byte offset
    localparam int SCR_OFS     = 18;    // first general-purpose byte
    localparam logic [DATA_W-1:0] STAT_ID_BITS = 8'h61; // sense code and colour marker
endpackage

// File: rtl/fbc_ctrl_status.sv
// Module: control byte, sticky pending flag and level interrupt.
// Assumes frame_end is a one-cycle pulse synchronous to clk.
// On a collision between an armed frame end and a status write, the set wins.
module fbc_ctrl_status
    import fbc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_end,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              pend_q,
    output logic              irq
);
    logic armed_evt;

    // Purpose: detect a frame end while the interrupt is armed.
    always_comb armed_evt = frame_end && ctrl_q[ARM_BIT];

    // Purpose: hold the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // Purpose: set the pending flag on an armed frame end, clear it on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (armed_evt) pend_q <= 1'b1;
        else if (stat_we)   pend_q <= 1'b0;
    end

    // Purpose: drive the level interrupt from the flag gated by the arm bit.
    always_comb irq = pend_q && ctrl_q[ARM_BIT];

    p_set_on_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && ctrl_q[ARM_BIT]) |=> pend_q);
    p_no_set_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !(frame_end && ctrl_q[ARM_BIT])) |=> !pend_q);
    p_clear_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !frame_end) |=> !pend_q);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && frame_end && ctrl_q[ARM_BIT]) |=> pend_q);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !stat_we) |=> pend_q);
endmodule

// File: rtl/fbc_scratch_bank.sv
// Module: a bank of independent general-purpose byte registers.
// Assumes the index is already decoded to lie inside the bank when we is high.
// Reads of an index beyond the bank return zero.
module fbc_scratch_bank #(
    parameter int NUM   = 14,
    parameter int WID   = 8,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WID-1:0]   wdata,
    output logic [WID-1:0]   rdata
);
    logic [WID-1:0] cell_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_cell
        // Purpose: store one byte when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)                             cell_q[g] <= '0;
            else if (we && idx == IDX_W'(g))        cell_q[g] <= wdata;
        end

        p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IDX_W'(g)) |=> cell_q[g] == $past(wdata));
    end

    // Purpose: select the addressed byte for reads.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM; i++) begin
            if (idx == IDX_W'(i)) rdata = cell_q[i];
        end
    end
endmodule

// File: rtl/fbc_irq_regs.sv
// Module: top of the framebuffer control register bank. Decodes the upper
// half of the register window and leaves the lower half as read-zero,
// write-ignored. Assumes single-cycle write strobes and combinational reads.
module fbc_irq_regs
    import fbc_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              frame_end,
    output logic              irq
);
    localparam int NUM_SCR = (1 << ADDR_W) - SCR_OFS;
    localparam int IDX_W   = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] SCR_A  = ADDR_W'(SCR_OFS);

    logic              sel_ctrl, sel_stat, sel_scr;
    logic [ADDR_W-1:0] scr_ofs;
    logic [IDX_W-1:0]  scr_idx;
    logic [7:0]        ctrl_q, scr_rdata;
    logic              pend_q;

    // Purpose: decode the address into register selects.
    always_comb begin
        sel_ctrl = (bus_addr == CTRL_A);
        sel_stat = (bus_addr == STAT_A);
        sel_scr  = (bus_addr >= SCR_A);
        scr_ofs  = bus_addr - SCR_A;
        scr_idx  = scr_ofs[IDX_W-1:0];
    end

    fbc_ctrl_status u_ctrl_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (bus_wr && sel_ctrl),
        .stat_we   (bus_wr && sel_stat),
        .wdata     (bus_wdata),
        .frame_end (frame_end),
        .ctrl_q    (ctrl_q),
        .pend_q    (pend_q),
        .irq       (irq)
    );

    fbc_scratch_bank #(.NUM(NUM_SCR), .WID(8)) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && sel_scr),
        .idx   (scr_idx),
        .wdata (bus_wdata),
        .rdata (scr_rdata)
    );

    // Purpose: return the addressed byte, merging ID bits into status reads.
    always_comb begin
        if (sel_ctrl)      bus_rdata = ctrl_q;
        else if (sel_stat) bus_rdata = {pend_q, 7'b0} | STAT_ID_BITS;
        else if (sel_scr)  bus_rdata = scr_rdata;
        else               bus_rdata = 8'h00;
    end

    p_irq_from_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(frame_end) || $past(bus_wr && sel_ctrl)));
endmodule

// File: tb/fbc_irq_regs_tb_top.sv
module fbc_irq_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frame_end = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_ctrl = 0;
    bit m_pend = 1'b0;
    int m_scr [14];

    always #2.5 clk = ~clk;

    fbc_irq_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_end(frame_end), .irq(irq)
    );

    function automatic int exp_read(int a);
        if (a == 16) return m_ctrl;
        if (a == 17) return (m_pend ? 8'h80 : 8'h00) | 8'h61;
        if (a >= 18) return m_scr[a - 18];
        return 0;
    endfunction

    // model update on each rising edge, from the stable inputs
    always @(posedge clk) begin
        int a;
        bit nxt;
        a = int'(bus_addr);
        if (!rst_n) begin
            m_ctrl = 0;
            m_pend = 1'b0;
            foreach (m_scr[i]) m_scr[i] = 0;
        end else begin
            nxt = m_pend;
            if (bus_wr && a == 17) nxt = 1'b0;
            if (frame_end && m_ctrl[7]) nxt = 1'b1;
            if (bus_wr && a == 16) m_ctrl = int'(bus_wdata);
            if (bus_wr && a >= 18) m_scr[a - 18] = int'(bus_wdata);
            m_pend = nxt;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        int a;
        bit ei;
        if (running) begin
            a = int'(bus_addr);
            ei = m_pend && m_ctrl[7];
            checks++;
            if (irq !== ei) begin
                errors++;
                $display("FAIL R10 irq per-cycle: got %0b expected %0b", irq, ei);
            end
            checks++;
            if (int'(bus_rdata) != exp_read(a)) begin
                errors++;
                $display("FAIL %s read 0x%02h per-cycle: got 0x%02h expected 0x%02h",
                    (a == 16) ? "R2" : (a == 17) ? "R6" : (a >= 18) ? "R8" : "R9",
                    a, bus_rdata, exp_read(a));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic do_write(input int a, input int d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = 8'(d); frame_end = 1'b0;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_frame();
        @(negedge clk); #1;
        bus_wr = 1'b0; frame_end = 1'b1;
        @(negedge clk); #1;
        frame_end = 1'b0;
    endtask

    task automatic do_both(input int d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = 5'd17; bus_wdata = 8'(d); frame_end = 1'b1;
        @(negedge clk); #1;
        bus_wr = 1'b0; frame_end = 1'b0;
    endtask

    task automatic peek(input int a, input int e, input string tag);
        @(negedge clk); #1;
        bus_wr = 1'b0; frame_end = 1'b0; bus_addr = 5'(a);
        @(negedge clk);
        checks++;
        if (int'(bus_rdata) != e) begin
            errors++;
            $display("FAIL %s read 0x%02h: got 0x%02h expected 0x%02h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic chk_irq(input bit e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq: got %0b expected %0b", tag, irq, e);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        running = 1'b1;

        // R1: reset state
        chk_irq(1'b0, "R1");
        peek(17, 8'h61, "R1");
        peek(16, 8'h00, "R1");
        peek(21, 8'h00, "R1");
        peek(31, 8'h00, "R1");

        // R2: control byte storage
        do_write(16, 8'h5A);
        peek(16, 8'h5A, "R2");

        // R4: unarmed frame end does nothing
        do_frame();
        chk_irq(1'b0, "R4");
        peek(17, 8'h61, "R4");

        // R3 / R6: armed frame end
        do_write(16, 8'h80);
        do_frame();
        chk_irq(1'b1, "R3");
        peek(17, 8'hE1, "R6");

        // R11: sticky across idle cycles
        repeat (5) @(negedge clk);
        peek(17, 8'hE1, "R11");

        // R10: irq follows arm bit while pending
        do_write(16, 8'h00);
        chk_irq(1'b0, "R10");
        peek(17, 8'hE1, "R10");
        do_write(16, 8'h80);
        chk_irq(1'b1, "R10");

        // R5: any value clears; write when clear is harmless
        do_write(17, 8'h00);
        chk_irq(1'b0, "R5");
        peek(17, 8'h61, "R5");
        do_write(17, 8'hFF);
        peek(17, 8'h61, "R5");

        // R7: collision, set wins
        do_frame();
        do_both(8'h3C);
        chk_irq(1'b1, "R7");
        peek(17, 8'hE1, "R7");
        do_write(17, 8'hA5);
        peek(17, 8'h61, "R5");

        // R8: general-purpose bytes independent
        for (int i = 0; i < 14; i++) do_write(18 + i, (8'h30 + i * 7) & 8'hFF);
        for (int i = 0; i < 14; i++) peek(18 + i, (8'h30 + i * 7) & 8'hFF, "R8");

        // R9: lower half reads zero and ignores writes
        do_write(3, 8'hAA);
        do_write(15, 8'h55);
        do_write(0, 8'hFF);
        peek(3, 8'h00, "R9");
        peek(15, 8'h00, "R9");
        peek(16, 8'h80, "R9");
        peek(17, 8'h61, "R9");
        for (int i = 0; i < 14; i++) peek(18 + i, (8'h30 + i * 7) & 8'hFF, "R9");

        // pseudo-random stream checked by the per-cycle model
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_addr  = 5'(16 + (lfsr[3:0] % 16));
            if (lfsr[14]) bus_addr = lfsr[4:0];
            bus_wr    = lfsr[5] & lfsr[6];
            bus_wdata = lfsr[15:8];
            frame_end = lfsr[7] & lfsr[9];
        end
        @(negedge clk); #1;
        bus_wr = 1'b0; frame_end = 1'b0;

        // R1: reset mid-run returns to initial state
        rst_n = 1'b0;
        @(negedge clk); #1;
        rst_n = 1'b1;
        chk_irq(1'b0, "R1");
        peek(17, 8'h61, "R1");
        peek(18, 8'h00, "R1");

        repeat (2) @(negedge clk);
        running = 1'b0;
        finish_run();
    end
endmodule